// File: doc/BRIEF.md
# Descriptor Ring Queue Engine

This block walks a circular chain of 16-byte transfer descriptors that software has laid out in memory for one endpoint queue. It reads each descriptor as four 32-bit words through a request/acknowledge word port. It then checks whether software has handed the descriptor to hardware, optionally validates a byte checksum over the descriptor, and skips descriptors marked for bypass. For every other descriptor it presents the buffer address and length to the data path. When the data path reports completion, the block writes the results back to memory, then follows the next-descriptor pointer.

Each descriptor holds these fields, in little-endian byte order:

| Word | Bits | Field |
|------|------|-------|
| 0 | [7:0] | flag byte |
| 0 | [15:8] | checksum byte |
| 0 | [31:16] | receive capacity |
| 1 | all | next-descriptor address |
| 2 | all | buffer address |
| 3 | [15:0] | buffer length |
| 3 | [23:16] | spare byte |
| 3 | [31:24] | extended flag byte |

Software loads a start address and pulses `ctl_start`. When the engine halts on a descriptor that software does not yet own, or after a checksum error, software fixes the memory and pulses `ctl_resume` to fetch the same descriptor again. A ring must hold at least two descriptors. The direction (`cfg_rx`) and the checksum enable may only change while the engine is idle.

The controller has seven states:

| State | What it does | Leaves for |
|-------|--------------|------------|
| IDLE | Waits for a command. | FETCH on start or resume. |
| FETCH | Reads the four descriptor words. | CHECK after the fourth acknowledge. |
| CHECK | Examines the fetched descriptor. | IDLE if the descriptor is not owned or the checksum fails; NEXT on bypass; XFER otherwise. |
| XFER | Waits for the data path to finish. | WB_LEN on done when receiving; WB_FLAG on done when transmitting. |
| WB_LEN | Writes the received length. | WB_FLAG on acknowledge. |
| WB_FLAG | Clears the hardware-own bit. | NEXT on acknowledge. |
| NEXT | Loads the next-descriptor pointer. | IDLE if a stop is pending; FETCH otherwise. |

Top module: `dring_queue_engine`

## Requirements
- R1: A `ctl_start` pulse while idle loads `cfg_start_addr` and reads words at offsets 0, 4, 8 and 12 from it. The fields sit in those words as shown in the descriptor table above.
- R2: A descriptor whose hardware-own bit (flag bit 0) is 0 halts the engine with no transfer and no write. A `ctl_resume` pulse re-reads that same descriptor.
- R3: A descriptor that is owned and has bypass (flag bit 2) set is skipped without a transfer or any write, and the engine goes on to its next pointer.
- R4: With `csum_en` high, an owned descriptor whose 16 bytes do not sum to 0xFF modulo 256 gives a one-cycle `irq_csum` pulse. The engine then halts with no transfer and no write. With `csum_en` low the checksum byte has no effect.
- R5: When transmitting (`cfg_rx`=0), `xfer_addr` is word 2 and `xfer_len` is word 3 bits [15:0]. `xfer_zlp` is extended flag bit 5 (word 3 bit 29).
- R6: When receiving (`cfg_rx`=1), `xfer_len` is word 0 bits [31:16] and `xfer_zlp` is 0. On completion the reported length is written to word 3 bits [15:0] with byte enables 0011, leaving the upper bytes intact.
- R7: On completion the engine writes the flag byte with bit 0 cleared, using byte enable 0001, after any length write. `irq_done` pulses for one cycle after that write only if the descriptor's interrupt-on-completion bit (flag bit 7) is set.
- R8: After completion or a bypass, the engine fetches the descriptor at the word 1 pointer.
- R9: A `ctl_stop` pulse while active lets the current descriptor finish. The engine then goes idle instead of fetching the next descriptor.
- R10: `mem_req` stays high with a stable address until `mem_ack`, and `xfer_req` stays high until `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_addr | input | 32 | First descriptor address |
| cfg_rx | input | 1 | 1 = receive queue, 0 = transmit queue |
| csum_en | input | 1 | Enable descriptor checksum validation |
| ctl_start | input | 1 | Start pulse from the start address |
| ctl_resume | input | 1 | Resume pulse from the held pointer |
| ctl_stop | input | 1 | Stop after the current descriptor |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_ack | input | 1 | Access accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| xfer_req | output | 1 | Transfer request to the data path |
| xfer_addr | output | 32 | Buffer address |
| xfer_len | output | 16 | Bytes to send or buffer capacity |
| xfer_zlp | output | 1 | Append a zero-length packet |
| xfer_done | input | 1 | Data path finished |
| xfer_act_len | input | 16 | Bytes actually moved |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_csum | output | 1 | Checksum error interrupt pulse |
| active | output | 1 | Engine is not idle |

## Verification
Each result falls due a fixed number of edges after the handshake that causes it. `xfer_req` rises two edges after the acknowledge of the fourth word. The length write follows `xfer_done` by one edge. `irq_done` is high for the single cycle after the flag write is acknowledged, and `irq_csum` for the cycle after CHECK. The bench's memory and data-path models react only to the handshakes, and every sample is taken on the falling edge, so the checks never depend on a guessed latency. The reference model holds an ordered queue of expected transfers and per-run interrupt counts, and compares them with what the ports show. It also reads the memory words afterwards to confirm which descriptors were written.

// File: rtl/dring_pkg.sv
package dring_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 4;
    localparam int DESC_BYTES = DESC_WORDS * WORD_W / 8;
    localparam int LEN_W      = 16;
    localparam int FLG_OWN    = 0;
    localparam int FLG_BYP    = 2;
    localparam int FLG_IOC    = 7;
    localparam int EXT_ZLP    = 5;
    localparam logic [7:0] CSUM_GOOD = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_CHECK, ST_XFER, ST_WB_LEN, ST_WB_FLAG, ST_NEXT
    } dr_state_e;

    typedef struct packed {
        logic [7:0]        flag;
        logic [WORD_W-1:0] next_ptr;
        logic [WORD_W-1:0] buf_addr;
        logic [LEN_W-1:0]  len;
        logic              zlp;
        logic              own;
        logic              byp;
        logic              ioc;
    } dr_desc_t;
endpackage

// File: rtl/dring_csum.sv
module dring_csum #(
    parameter int NBYTES = 16
) (
    input  logic [NBYTES*8-1:0] blob,
    output logic [7:0]          sum
);
    logic [7:0] part [NBYTES+1];

    assign part[0] = 8'h00;
    for (genvar g = 0; g < NBYTES; g++) begin : g_add
        assign part[g+1] = part[g] + blob[g*8 +: 8];
    end
    assign sum = part[NBYTES];
endmodule

// File: rtl/dring_decode.sv
module dring_decode
    import dring_pkg::*;
(
    input  logic [DESC_WORDS*WORD_W-1:0] blob,
    input  logic                         is_rx,
    output dr_desc_t                     desc
);
    logic [WORD_W-1:0] w0, w1, w2, w3;

    assign w0 = blob[0*WORD_W +: WORD_W];
    assign w1 = blob[1*WORD_W +: WORD_W];
    assign w2 = blob[2*WORD_W +: WORD_W];
    assign w3 = blob[3*WORD_W +: WORD_W];

    always_comb begin
        desc.flag     = w0[7:0];
        desc.next_ptr = w1;
        desc.buf_addr = w2;
        desc.len      = is_rx ? w0[31:16] : w3[15:0];
        desc.zlp      = !is_rx && w3[24 + EXT_ZLP];
        desc.own      = w0[FLG_OWN];
        desc.byp      = w0[FLG_BYP];
        desc.ioc      = w0[FLG_IOC];
    end
endmodule

// File: rtl/dring_queue_engine.sv
module dring_queue_engine
    import dring_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cfg_start_addr,
    input  logic              cfg_rx,
    input  logic              csum_en,
    input  logic              ctl_start,
    input  logic              ctl_resume,
    input  logic              ctl_stop,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              xfer_req,
    output logic [WORD_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              xfer_zlp,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_act_len,
    output logic              irq_done,
    output logic              irq_csum,
    output logic              active
);
    localparam int CNT_W  = $clog2(DESC_WORDS);
    localparam int BLOB_W = DESC_WORDS * WORD_W;

    dr_state_e          st_q, st_d;
    logic [WORD_W-1:0]  ptr_q;
    logic [CNT_W-1:0]   wcnt_q;
    logic [BLOB_W-1:0]  blob_q;
    logic [LEN_W-1:0]   alen_q;
    logic               stop_q;
    logic               irq_done_q, irq_csum_q;
    logic [7:0]         sum;
    logic               csum_bad;
    logic               last_word;
    dr_desc_t           desc;

    dring_csum #(.NBYTES(DESC_BYTES)) u_csum (.blob(blob_q), .sum(sum));
    dring_decode u_dec (.blob(blob_q), .is_rx(cfg_rx), .desc(desc));

    assign csum_bad  = csum_en && (sum != CSUM_GOOD);
    assign last_word = (wcnt_q == CNT_W'(DESC_WORDS - 1));

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (ctl_start || ctl_resume) st_d = ST_FETCH;
            ST_FETCH:   if (mem_ack && last_word) st_d = ST_CHECK;
            ST_CHECK: begin
                if (!desc.own || csum_bad) st_d = ST_IDLE;
                else if (desc.byp)         st_d = ST_NEXT;
                else                       st_d = ST_XFER;
            end
            ST_XFER:    if (xfer_done) st_d = cfg_rx ? ST_WB_LEN : ST_WB_FLAG;
            ST_WB_LEN:  if (mem_ack) st_d = ST_WB_FLAG;
            ST_WB_FLAG: if (mem_ack) st_d = ST_NEXT;
            ST_NEXT:    st_d = (stop_q || ctl_stop) ? ST_IDLE : ST_FETCH;
            default:    st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            wcnt_q     <= '0;
            blob_q     <= '0;
            alen_q     <= '0;
            stop_q     <= 1'b0;
            irq_done_q <= 1'b0;
            irq_csum_q <= 1'b0;
        end else begin
            irq_done_q <= 1'b0;
            irq_csum_q <= 1'b0;
            if (st_q == ST_IDLE) begin
                stop_q <= 1'b0;
                wcnt_q <= '0;
                if (ctl_start) ptr_q <= cfg_start_addr;
            end else if (ctl_stop) begin
                stop_q <= 1'b1;
            end
            if (st_q == ST_FETCH && mem_ack) begin
                blob_q[{wcnt_q, 5'b0} +: WORD_W] <= mem_rdata;
                wcnt_q <= wcnt_q + 1'b1;
            end
            if (st_q == ST_CHECK && desc.own && csum_bad) irq_csum_q <= 1'b1;
            if (st_q == ST_XFER && xfer_done) alen_q <= xfer_act_len;
            if (st_q == ST_WB_FLAG && mem_ack) irq_done_q <= desc.ioc;
            if (st_q == ST_NEXT) begin
                ptr_q  <= desc.next_ptr;
                wcnt_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_q;
        mem_wdata = '0;
        mem_be    = 4'b0000;
        unique case (st_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + {{(WORD_W-CNT_W-2){1'b0}}, wcnt_q, 2'b00};
            end
            ST_WB_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_q + WORD_W'(12);
                mem_wdata = {{(WORD_W-LEN_W){1'b0}}, alen_q};
                mem_be    = 4'b0011;
            end
            ST_WB_FLAG: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {24'h0, desc.flag & ~8'(1 << FLG_OWN)};
                mem_be    = 4'b0001;
            end
            default: ;
        endcase
    end

    assign xfer_req  = (st_q == ST_XFER);
    assign xfer_addr = desc.buf_addr;
    assign xfer_len  = desc.len;
    assign xfer_zlp  = desc.zlp;
    assign irq_done  = irq_done_q;
    assign irq_csum  = irq_csum_q;
    assign active    = (st_q != ST_IDLE);

    a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    a_r10_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_done |=> xfer_req);
    a_r7_irq_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> $past(mem_ack && mem_we && mem_be == 4'b0001));
    a_r4_csum_halts: assert property (@(posedge clk) disable iff (!rst_n)
        irq_csum |-> !active && !irq_done);
    a_r6_len_write_rx: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_be == 4'b0011 |-> cfg_rx);
    a_r5_zlp_tx_only: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_zlp && xfer_req |-> !cfg_rx);
endmodule

// File: tb/dring_queue_engine_bench.sv
module dring_queue_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_start_addr = '0;
    logic        cfg_rx = 1'b0, csum_en = 1'b0;
    logic        ctl_start = 1'b0, ctl_resume = 1'b0, ctl_stop = 1'b0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [3:0]  mem_be;
    logic        xfer_req, xfer_zlp, xfer_done = 1'b0;
    logic [31:0] xfer_addr;
    logic [15:0] xfer_len, xfer_act_len = '0;
    logic        irq_done, irq_csum, active;

    always #10 clk = ~clk;

    dring_queue_engine u_dring_queue_engine (.*);

    int total = 0, bad = 0, n_done = 0, n_csum = 0, n_xfer = 0;
    bit finished = 0;
    logic [31:0] mem [256];

    typedef struct { logic [31:0] addr; logic [15:0] len; logic zlp; logic [15:0] act; } exp_t;
    exp_t exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_rdata <= mem[mem_addr[9:2]];
            if (mem_we)
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end
        mem_ack <= mem_req && !mem_ack;
    end

    // data path model compared with the expected transfer queue
    initial begin
        forever begin
            @(negedge clk);
            if (irq_done) n_done++;
            if (irq_csum) n_csum++;
            if (xfer_req) begin
                exp_t e;
                n_xfer++;
                if (exp_q.size() == 0) begin
                    chk(0, "R2", "unexpected transfer", xfer_addr, 0);
                    e.act = 0;
                end else begin
                    e = exp_q.pop_front();
                    chk(xfer_addr == e.addr, "R5", "xfer_addr", xfer_addr, e.addr);
                    chk(xfer_len == e.len, "R6", "xfer_len", xfer_len, e.len);
                    chk(xfer_zlp == e.zlp, "R5", "xfer_zlp", xfer_zlp, e.zlp);
                end
                repeat (2) begin
                    @(negedge clk);
                    if (irq_done) n_done++;
                end
                xfer_done = 1'b1; xfer_act_len = e.act;
                @(negedge clk);
                xfer_done = 1'b0;
                if (irq_done) n_done++;
            end
        end
    end

    function automatic logic [7:0] byte_sum(input logic [31:0] w0, w1, w2, w3);
        logic [7:0] s = 0;
        for (int b = 0; b < 4; b++) s = s + w0[b*8+:8] + w1[b*8+:8] + w2[b*8+:8] + w3[b*8+:8];
        return s;
    endfunction

    task automatic put_desc(input int base, input logic [7:0] flag, input logic [15:0] rxsz,
                            input logic [31:0] nxt, buffer, input logic [15:0] blen,
                            input logic [7:0] ext, input bit good);
        logic [31:0] w0, w3;
        logic [7:0] cs;
        w0 = {rxsz, 8'h00, flag};
        w3 = {ext, 8'h5A, blen};
        cs = 8'hFF - byte_sum(w0, nxt, buffer, w3);
        if (!good) cs = cs + 8'h01;
        w0[15:8] = cs;
        mem[base/4] = w0; mem[base/4+1] = nxt; mem[base/4+2] = buffer; mem[base/4+3] = w3;
    endtask

    task automatic push_exp(input logic [31:0] a, input logic [15:0] l, input logic z,
                            input logic [15:0] act);
        exp_t e;
        e.addr = a; e.len = l; e.zlp = z; e.act = act;
        exp_q.push_back(e);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) ctl_start = 1'b1; else if (which == 1) ctl_resume = 1'b1; else ctl_stop = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0; ctl_resume = 1'b0; ctl_stop = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (active && n < 5000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
        chk(!active, req, "engine did not go idle", active, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        int d0, x0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!active, "R1", "reset active", active, 0);
        chk(!mem_req, "R10", "reset mem_req", mem_req, 0);
        chk(!xfer_req, "R10", "reset xfer_req", xfer_req, 0);
        chk(!irq_done && !irq_csum, "R7", "reset irq", {irq_done, irq_csum}, 0);

        // transmit ring, checksum disabled (bad checksums ignored, R4)
        put_desc(32'h100, 8'h81, 16'h0, 32'h110, 32'h4000_0000, 16'd20, 8'h20, 0);
        put_desc(32'h110, 8'h05, 16'h0, 32'h120, 32'h4000_1000, 16'd99, 8'h00, 0);
        put_desc(32'h120, 8'h01, 16'h0, 32'h130, 32'h4000_2000, 16'd8,  8'h00, 0);
        put_desc(32'h130, 8'h00, 16'h0, 32'h100, 32'h4000_3000, 16'd4,  8'h00, 0);
        push_exp(32'h4000_0000, 16'd20, 1'b1, 16'd20);
        push_exp(32'h4000_2000, 16'd8,  1'b0, 16'd8);
        d0 = n_done; x0 = n_xfer;
        cfg_start_addr = 32'h100;
        pulse(0);
        wait_idle("R2");
        chk(n_xfer - x0 == 2, "R3", "transfers with bypass", n_xfer - x0, 2);
        chk(exp_q.size() == 0, "R8", "remaining expected", exp_q.size(), 0);
        chk(n_done - d0 == 1, "R7", "irq_done count", n_done - d0, 1);
        chk(mem[32'h100/4][7:0] == 8'h80, "R7", "own cleared d0", mem[32'h100/4][7:0], 8'h80);
        chk(mem[32'h110/4][7:0] == 8'h05, "R3", "bypass flag kept", mem[32'h110/4][7:0], 8'h05);
        chk(mem[32'h120/4][7:0] == 8'h00, "R7", "own cleared d2", mem[32'h120/4][7:0], 8'h00);
        chk(mem[32'h100/4+3] == 32'h205A_0014, "R6", "tx word3 untouched", mem[32'h100/4+3], 32'h205A_0014);
        chk(n_csum == 0, "R4", "csum ignored when disabled", n_csum, 0);

        // resume from the held descriptor
        put_desc(32'h130, 8'h81, 16'h0, 32'h100, 32'h4000_3000, 16'd4, 8'h00, 0);
        push_exp(32'h4000_3000, 16'd4, 1'b0, 16'd4);
        d0 = n_done; x0 = n_xfer;
        pulse(1);
        wait_idle("R2");
        chk(n_xfer - x0 == 1, "R2", "resume transfers", n_xfer - x0, 1);
        chk(n_done - d0 == 1, "R7", "resume irq_done", n_done - d0, 1);
        chk(mem[32'h130/4][0] == 1'b0, "R2", "resumed own cleared", mem[32'h130/4][0], 0);

        // receive ring with checksum checking
        cfg_rx = 1'b1; csum_en = 1'b1;
        put_desc(32'h200, 8'h81, 16'd64, 32'h210, 32'h5000, 16'd0, 8'h20, 1);
        put_desc(32'h210, 8'h81, 16'd32, 32'h200, 32'h5100, 16'd0, 8'h00, 0);
        push_exp(32'h5000, 16'd64, 1'b0, 16'd37);
        d0 = n_done; x0 = n_xfer;
        cfg_start_addr = 32'h200;
        pulse(0);
        wait_idle("R4");
        chk(n_xfer - x0 == 1, "R4", "no transfer on bad checksum", n_xfer - x0, 1);
        chk(n_csum == 1, "R4", "irq_csum count", n_csum, 1);
        chk(mem[32'h200/4+3] == 32'h205A_0025, "R6", "rx length write", mem[32'h200/4+3], 32'h205A_0025);
        chk(mem[32'h200/4][7:0] == 8'h80, "R7", "rx own cleared", mem[32'h200/4][7:0], 8'h80);
        chk(mem[32'h210/4][7:0] == 8'h81, "R4", "bad desc untouched", mem[32'h210/4][7:0], 8'h81);
        put_desc(32'h210, 8'h81, 16'd32, 32'h200, 32'h5100, 16'd0, 8'h00, 1);
        push_exp(32'h5100, 16'd32, 1'b0, 16'd5);
        pulse(1);
        wait_idle("R4");
        chk(n_xfer - x0 == 2, "R8", "fixed checksum proceeds", n_xfer - x0, 2);
        chk(mem[32'h210/4+3] == 32'h005A_0005, "R6", "second rx length", mem[32'h210/4+3], 32'h005A_0005);
        chk(n_done - d0 == 2, "R7", "rx irq_done count", n_done - d0, 2);

        // stop request during a transfer
        cfg_rx = 1'b0; csum_en = 1'b0;
        put_desc(32'h300, 8'h01, 16'h0, 32'h310, 32'h6000, 16'd3, 8'h00, 0);
        put_desc(32'h310, 8'h01, 16'h0, 32'h300, 32'h6100, 16'd3, 8'h00, 0);
        push_exp(32'h6000, 16'd3, 1'b0, 16'd3);
        x0 = n_xfer;
        cfg_start_addr = 32'h300;
        pulse(0);
        begin
            int n = 0;
            while (!xfer_req && n < 2000) begin @(negedge clk); n++; end
        end
        pulse(2);
        wait_idle("R9");
        chk(n_xfer - x0 == 1, "R9", "stop after one transfer", n_xfer - x0, 1);
        chk(mem[32'h310/4][0] == 1'b1, "R9", "next desc not taken", mem[32'h310/4][0], 1);
        chk(mem[32'h300/4][0] == 1'b0, "R9", "current desc finished", mem[32'h300/4][0], 0);
        summary();
    end
endmodule